// File: doc/BRIEF.md
# I2C Target for a 16-bit Register Bank

This block is an I2C bus target that gives an external master read and write access to a bank of 16-bit registers. It watches the open-drain SCL and SDA lines through a synchroniser clocked by the system clock. It recognises START, repeated START and STOP conditions and answers a device address whose two lowest bits are don't-care. After the address it takes an 8-bit register pointer. It then moves 16-bit words as high/low byte pairs, and the pointer advances by itself after each word.

Towards the chip the block presents a plain register-file port. This port has an address that follows the internal pointer, a 16-bit write word with a one-cycle write strobe, and a read word that the register file returns combinationally for the presented address. The pointer saturates at the last register. Further write pairs are then dropped, and further reads keep returning the last register. A pointer loaded beyond the bank is clipped to the last register and treated the same way.

Top module: `i2c16_target`

## Requirements
- R1: A START (SDA falling while SCL is high) or a STOP (SDA rising while SCL is high) releases SDA within one cycle of detection. A START, including a repeated START, restarts address reception at the next byte.
- R2: The block acknowledges (drives SDA low during the ninth clock) a 7-bit address whose upper five bits equal 01011, for any value of the two low bits. A non-matching address is not acknowledged, and the block leaves SDA and the register port untouched until the next START.
- R3: After reset the pointer (`reg_addr`) is 0. In a write transaction (R/W bit 0) the first byte after the address is loaded as the pointer and acknowledged.
- R4: The data bytes of a write are taken in pairs: high byte first, then low byte. One cycle after the low byte completes, `reg_we` pulses for exactly one cycle with `reg_wdata = {high, low}` at the current pointer. A trailing unpaired byte produces no write. Every data byte is acknowledged.
- R5: In the cycle after a `reg_we` pulse, the pointer advances by one, unless it already holds the last register index.
- R6: Once a write has committed at the last register, or once a pointer value at or above the register count has been loaded, later write pairs in the same pointer run produce no `reg_we`. An over-range pointer is clipped to the last register.
- R7: In a read transaction (R/W bit 1) the block sends the high byte and then the low byte of the addressed register, most significant bit first. The pointer advances by one for each register sent.
- R8: When reads continue at the last register, each further pair returns the contents of the last register.
- R9: When the master answers a byte with NACK, the block stops driving SDA and stays silent on later clocks until the next START.
- R10: A repeated START directly after a pointer write is accepted. The following read starts at the pointer just written.
- R11: The block changes its SDA drive only while SCL is low, apart from the release on START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1 (open-drain enable) |
| reg_addr | output | $clog2(NUM_REGS) | Register index presented to the register file (the pointer) |
| reg_wdata | output | 16 | Word to write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 16 | Word read from `reg_addr`, combinational |

## Verification
The bench builds the block with NUM_REGS set to 8 instead of 64. With that value, a write or read run started at index 6 crosses the last register within a few bytes, so saturation, dropped writes and repeated last-register reads are reached without long transactions. A pointer byte of 200 or 240 exceeds the bank by a wide margin and exercises the clipping path. The address and ignore-bit parameters stay at their defaults, so every variant of the two don't-care bits and two near-miss addresses are driven against the real comparison.

// File: rtl/i2c16_pkg.sv
package i2c16_pkg;

   localparam int BYTE_BITS = 8;
   localparam int WORD_BITS = 16;

   typedef enum logic [2:0] {
      BUS_IDLE,
      BUS_RX,
      BUS_RX_ACK,
      BUS_TX,
      BUS_TX_ACK
   } bus_state_e;

   typedef enum logic [1:0] {
      BYTE_DEV,
      BYTE_PTR,
      BYTE_HI,
      BYTE_LO
   } byte_role_e;

endpackage

// File: rtl/i2c16_sync.sv
module i2c16_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c16_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_d;
   logic              sda_d;

   // idle bus level is high, so the pipes reset to ones
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_d    <= 1'b1;
         sda_d    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_d    <= scl_pipe[STAGES-1];
         sda_d    <= sda_pipe[STAGES-1];
      end
   end

   assign scl_s     = scl_pipe[STAGES-1];
   assign sda_s     = sda_pipe[STAGES-1];
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c16_ptr.sv
module i2c16_ptr #(
   parameter int NUM_REGS = 64,
   parameter int AW       = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [7:0]    load_val,
   input  logic          inc,
   output logic [AW-1:0] ptr,
   output logic          past_end
);

   localparam int            MAX_I = NUM_REGS - 1;
   localparam logic [AW-1:0] MAX_A = AW'(MAX_I);

   generate
      if (NUM_REGS < 2 || NUM_REGS > 256) begin : g_bad_depth
         $error("i2c16_ptr: NUM_REGS must lie in 2..256");
      end
      if (AW != $clog2(NUM_REGS)) begin : g_bad_aw
         $error("i2c16_ptr: AW must equal clog2(NUM_REGS)");
      end
   endgenerate

   // past_end marks that the last register has been consumed (or the
   // loaded value lay beyond the bank); it gates further writes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr      <= '0;
         past_end <= 1'b0;
      end else if (load) begin
         if (int'(load_val) > MAX_I) begin
            ptr      <= MAX_A;
            past_end <= 1'b1;
         end else begin
            ptr      <= load_val[AW-1:0];
            past_end <= 1'b0;
         end
      end else if (inc) begin
         if (ptr == MAX_A) begin
            past_end <= 1'b1;
         end else begin
            ptr <= ptr + 1'b1;
         end
      end
   end

endmodule

// File: rtl/i2c16_engine.sv
module i2c16_engine
   import i2c16_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h2C,
   parameter int         IGNORE_LSBS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sda_s,
   input  logic                 scl_rise,
   input  logic                 scl_fall,
   input  logic                 start_det,
   input  logic                 stop_det,
   input  logic [WORD_BITS-1:0] rd_word,
   input  logic                 past_end,
   output logic                 sda_oe,
   output logic                 ptr_load,
   output logic [BYTE_BITS-1:0] ptr_val,
   output logic                 ptr_inc,
   output logic                 wr_en,
   output logic [WORD_BITS-1:0] wr_word
);

   localparam int CNT_W = $clog2(BYTE_BITS + 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_BITS);
   localparam logic [CNT_W-1:0] LAST_TX  = CNT_W'(BYTE_BITS - 1);

   generate
      if (IGNORE_LSBS < 0 || IGNORE_LSBS > 6) begin : g_bad_ignore
         $error("i2c16_engine: IGNORE_LSBS must lie in 0..6");
      end
   endgenerate

   bus_state_e           state;
   byte_role_e           role;
   logic [CNT_W-1:0]     bitcnt;
   logic [BYTE_BITS-1:0] rx_sh;
   logic [BYTE_BITS-1:0] hi_q;
   logic [BYTE_BITS-1:0] tx_sh;
   logic [BYTE_BITS-1:0] lo_q;
   logic                 next_lo;
   logic                 is_read;
   logic                 nack_q;
   logic                 rd_inc_q;
   logic                 addr_hit;

   // device address compare; the low bits may be excluded
   generate
      if (IGNORE_LSBS == 0) begin : g_match_full
         assign addr_hit = (rx_sh[7:1] == DEV_ADDR);
      end else begin : g_match_masked
         assign addr_hit = (rx_sh[7:IGNORE_LSBS+1] == DEV_ADDR[6:IGNORE_LSBS]);
      end
   endgenerate

   assign ptr_inc = wr_en | rd_inc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= BUS_IDLE;
         role     <= BYTE_DEV;
         bitcnt   <= '0;
         rx_sh    <= '0;
         hi_q     <= '0;
         tx_sh    <= '0;
         lo_q     <= '0;
         next_lo  <= 1'b0;
         is_read  <= 1'b0;
         nack_q   <= 1'b0;
         rd_inc_q <= 1'b0;
         sda_oe   <= 1'b0;
         ptr_load <= 1'b0;
         ptr_val  <= '0;
         wr_en    <= 1'b0;
         wr_word  <= '0;
      end else begin
         ptr_load <= 1'b0;
         wr_en    <= 1'b0;
         rd_inc_q <= 1'b0;
         if (start_det) begin
            state   <= BUS_RX;
            role    <= BYTE_DEV;
            bitcnt  <= '0;
            is_read <= 1'b0;
            sda_oe  <= 1'b0;
         end else if (stop_det) begin
            state  <= BUS_IDLE;
            sda_oe <= 1'b0;
         end else begin
            unique case (state)
               BUS_IDLE: begin
                  sda_oe <= 1'b0;
               end
               BUS_RX: begin
                  if (scl_rise && bitcnt != FULL_CNT) begin
                     rx_sh  <= {rx_sh[BYTE_BITS-2:0], sda_s};
                     bitcnt <= bitcnt + 1'b1;
                  end else if (scl_fall && bitcnt == FULL_CNT) begin
                     unique case (role)
                        BYTE_DEV: begin
                           if (addr_hit) begin
                              is_read <= rx_sh[0];
                              role    <= BYTE_PTR;
                              state   <= BUS_RX_ACK;
                              sda_oe  <= 1'b1;
                           end else begin
                              state <= BUS_IDLE;
                           end
                        end
                        BYTE_PTR: begin
                           ptr_load <= 1'b1;
                           ptr_val  <= rx_sh;
                           role     <= BYTE_HI;
                           state    <= BUS_RX_ACK;
                           sda_oe   <= 1'b1;
                        end
                        BYTE_HI: begin
                           hi_q   <= rx_sh;
                           role   <= BYTE_LO;
                           state  <= BUS_RX_ACK;
                           sda_oe <= 1'b1;
                        end
                        BYTE_LO: begin
                           wr_en   <= ~past_end;
                           wr_word <= {hi_q, rx_sh};
                           role    <= BYTE_HI;
                           state   <= BUS_RX_ACK;
                           sda_oe  <= 1'b1;
                        end
                        default: state <= BUS_IDLE;
                     endcase
                  end
               end
               BUS_RX_ACK: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (is_read) begin
                        // whole word is latched so both halves match
                        state   <= BUS_TX;
                        tx_sh   <= rd_word[WORD_BITS-1:BYTE_BITS];
                        lo_q    <= rd_word[BYTE_BITS-1:0];
                        next_lo <= 1'b1;
                        sda_oe  <= ~rd_word[WORD_BITS-1];
                     end else begin
                        state  <= BUS_RX;
                        sda_oe <= 1'b0;
                     end
                  end
               end
               BUS_TX: begin
                  if (scl_fall) begin
                     if (bitcnt == LAST_TX) begin
                        state  <= BUS_TX_ACK;
                        sda_oe <= 1'b0;
                     end else begin
                        tx_sh  <= {tx_sh[BYTE_BITS-2:0], 1'b0};
                        sda_oe <= ~tx_sh[BYTE_BITS-2];
                        bitcnt <= bitcnt + 1'b1;
                     end
                  end
               end
               BUS_TX_ACK: begin
                  if (scl_rise) begin
                     nack_q <= sda_s;
                  end else if (scl_fall) begin
                     if (nack_q) begin
                        state <= BUS_IDLE;
                     end else begin
                        state  <= BUS_TX;
                        bitcnt <= '0;
                        if (next_lo) begin
                           tx_sh    <= lo_q;
                           sda_oe   <= ~lo_q[BYTE_BITS-1];
                           next_lo  <= 1'b0;
                           rd_inc_q <= 1'b1;
                        end else begin
                           tx_sh   <= rd_word[WORD_BITS-1:BYTE_BITS];
                           lo_q    <= rd_word[BYTE_BITS-1:0];
                           sda_oe  <= ~rd_word[WORD_BITS-1];
                           next_lo <= 1'b1;
                        end
                     end
                  end
               end
               default: begin
                  state  <= BUS_IDLE;
                  sda_oe <= 1'b0;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/i2c16_target.sv
module i2c16_target
   import i2c16_pkg::*;
#(
   parameter int         NUM_REGS    = 64,
   parameter logic [6:0] DEV_ADDR    = 7'h2C,
   parameter int         IGNORE_LSBS = 2,
   parameter int         SYNC_STAGES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        scl_i,
   input  logic                        sda_i,
   output logic                        sda_oe,
   output logic [$clog2(NUM_REGS)-1:0] reg_addr,
   output logic [15:0]                 reg_wdata,
   output logic                        reg_we,
   input  logic [15:0]                 reg_rdata
);

   localparam int AW = $clog2(NUM_REGS);

   logic                 scl_s;
   logic                 sda_s;
   logic                 scl_rise;
   logic                 scl_fall;
   logic                 start_det;
   logic                 stop_det;
   logic                 ptr_load;
   logic [BYTE_BITS-1:0] ptr_val;
   logic                 ptr_inc;
   logic                 past_end;

   i2c16_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c16_engine #(
      .DEV_ADDR    (DEV_ADDR),
      .IGNORE_LSBS (IGNORE_LSBS)
   ) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .rd_word   (reg_rdata),
      .past_end  (past_end),
      .sda_oe    (sda_oe),
      .ptr_load  (ptr_load),
      .ptr_val   (ptr_val),
      .ptr_inc   (ptr_inc),
      .wr_en     (reg_we),
      .wr_word   (reg_wdata)
   );

   i2c16_ptr #(
      .NUM_REGS (NUM_REGS),
      .AW       (AW)
   ) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ptr_load),
      .load_val (ptr_val),
      .inc      (ptr_inc),
      .ptr      (reg_addr),
      .past_end (past_end)
   );

endmodule

// File: rtl/i2c16_target_chk.sv
module i2c16_target_chk #(
   parameter int NUM_REGS = 64
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        scl_s,
   input logic                        start_det,
   input logic                        stop_det,
   input logic                        sda_oe,
   input logic                        reg_we,
   input logic [$clog2(NUM_REGS)-1:0] reg_addr
);

   localparam logic [$clog2(NUM_REGS)-1:0] LAST = ($clog2(NUM_REGS))'(NUM_REGS - 1);

   // R4: each committed pair yields a single strobe
   p_we_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   // R5: pointer steps once after a commit, holding at the last index
   p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> ((reg_addr == $past(reg_addr) + 1'b1) ||
                  ($past(reg_addr) == LAST && reg_addr == LAST)));

   // R1: START releases the data line
   p_start_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !sda_oe);

   // R1: STOP releases the data line
   p_stop_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);

   // R11: drive changes only while the clock line is low
   p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sda_oe) && !$past(start_det) && !$past(stop_det)) |-> !scl_s);

endmodule

bind i2c16_target i2c16_target_chk #(
   .NUM_REGS (NUM_REGS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .scl_s     (scl_s),
   .start_det (start_det),
   .stop_det  (stop_det),
   .sda_oe    (sda_oe),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr)
);

// File: tb/i2c16_target_test.sv
module i2c16_target_test;

   localparam int N  = 8;
   localparam int AW = $clog2(N);
   localparam int Q  = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          scl_m = 1'b1;
   logic          sda_m = 1'b1;
   logic          sda_oe;
   logic [AW-1:0] reg_addr;
   logic [15:0]   reg_wdata;
   logic          reg_we;
   logic [15:0]   reg_rdata;
   wire           sda_bus = sda_m & ~sda_oe;

   logic [15:0]   rf [N];
   logic [15:0]   mdl [N];
   int            mptr = 0;
   bit            mpast = 1'b0;
   logic [23:0]   exp_q [$];
   int            vectors = 0;
   int            fails = 0;
   bit            quiet = 1'b0;
   logic          prev_oe = 1'b0;

   always #2 clk = ~clk;

   i2c16_target #(.NUM_REGS(N)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_m),
      .sda_i     (sda_bus),
      .sda_oe    (sda_oe),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_we    (reg_we),
      .reg_rdata (reg_rdata)
   );

   assign reg_rdata = rf[reg_addr];

   always_ff @(posedge clk) begin
      if (reg_we) rf[reg_addr] <= reg_wdata;
   end

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   // per-clock comparison against the expected-write queue and drive rules
   always @(negedge clk) begin
      if (rst_n) begin
         if (reg_we) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R4/R6 unexpected write", {8'h0, 5'h0, reg_addr, reg_wdata}, 32'h0);
            end else begin
               logic [23:0] e;
               e = exp_q.pop_front();
               check({8'h0, 5'h0, reg_addr, reg_wdata} == {8'h0, e},
                     "R4 write word/address", {8'h0, 5'h0, reg_addr, reg_wdata}, {8'h0, e});
            end
         end
         if (sda_oe != prev_oe) begin
            check(!scl_m, "R11 drive change with SCL high", 32'(scl_m), 32'h0);
         end
         if (quiet && sda_oe) begin
            check(1'b0, "R2/R9 drive while silent", 32'(sda_oe), 32'h0);
         end
         prev_oe = sda_oe;
      end
   end

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wq();
      scl_m = 1'b1; wq(); wq();
      sda_m = 1'b0; wq(); wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq();
      scl_m = 1'b1; wq(); wq();
      sda_m = 1'b1; wq(); wq();
   endtask

   task automatic bus_bit(input logic b, output logic s);
      sda_m = b; wq();
      scl_m = 1'b1; wq();
      s = sda_bus; wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic send_byte(input logic [7:0] b, output bit ack);
      logic s;
      for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
      bus_bit(1'b1, s);
      ack = !s;
   endtask

   task automatic recv_byte(input bit give_ack, output logic [7:0] d);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         bus_bit(1'b1, s);
         d[i] = s;
      end
      bus_bit(!give_ack, s);
   endtask

   task automatic model_load(input logic [7:0] p);
      if (int'(p) > N - 1) begin
         mptr  = N - 1;
         mpast = 1'b1;
      end else begin
         mptr  = int'(p);
         mpast = 1'b0;
      end
   endtask

   task automatic model_step();
      if (mptr == N - 1) mpast = 1'b1;
      else mptr++;
   endtask

   task automatic wr_txn(input logic [6:0] dev, input logic [7:0] p,
                         input logic [7:0] data [$]);
      bit          ack;
      logic [7:0]  hi;
      logic [15:0] w;
      hi = 8'h0;
      bus_start();
      send_byte({dev, 1'b0}, ack);
      check(ack, "R2 address ack (write)", 32'(ack), 32'h1);
      send_byte(p, ack);
      check(ack, "R3 pointer ack", 32'(ack), 32'h1);
      model_load(p);
      foreach (data[k]) begin
         if (k % 2 == 0) begin
            hi = data[k];
         end else begin
            w = {hi, data[k]};
            if (!mpast) begin
               exp_q.push_back({8'(mptr), w});
               mdl[mptr] = w;
               model_step();
            end
         end
         send_byte(data[k], ack);
         check(ack, "R4 data byte ack", 32'(ack), 32'h1);
      end
      bus_stop();
      check(exp_q.size() == 0, "R4/R6 pending writes after stop", 32'(exp_q.size()), 32'h0);
      check(int'(reg_addr) == mptr, "R5/R6 pointer after write", 32'(reg_addr), 32'(mptr));
   endtask

   task automatic rd_txn(input logic [6:0] dev, input bit use_ptr,
                         input logic [7:0] p, input int nregs);
      bit          ack;
      logic [7:0]  d;
      logic [15:0] e;
      logic        s;
      bus_start();
      if (use_ptr) begin
         send_byte({dev, 1'b0}, ack);
         check(ack, "R10 address ack before repeated START", 32'(ack), 32'h1);
         send_byte(p, ack);
         check(ack, "R10 pointer ack before repeated START", 32'(ack), 32'h1);
         model_load(p);
         bus_start();
      end
      send_byte({dev, 1'b1}, ack);
      check(ack, "R2/R10 address ack (read)", 32'(ack), 32'h1);
      for (int r = 0; r < nregs; r++) begin
         e = mdl[mptr];
         recv_byte(1'b1, d);
         check(d == e[15:8], "R7/R8 read high byte", 32'(d), 32'(e[15:8]));
         recv_byte(r != nregs - 1, d);
         check(d == e[7:0], "R7/R8 read low byte", 32'(d), 32'(e[7:0]));
         model_step();
      end
      // after the NACK the target must stay off the line
      quiet = 1'b1;
      bus_bit(1'b1, s);
      check(s == 1'b1, "R9 SDA released after NACK", 32'(s), 32'h1);
      bus_bit(1'b1, s);
      check(s == 1'b1, "R9 SDA still released", 32'(s), 32'h1);
      bus_stop();
      quiet = 1'b0;
      check(int'(reg_addr) == mptr, "R7 pointer after read", 32'(reg_addr), 32'(mptr));
   endtask

   task automatic foreign_txn(input logic [6:0] dev);
      bit ack;
      quiet = 1'b1;
      bus_start();
      send_byte({dev, 1'b0}, ack);
      check(!ack, "R2 foreign address not acked", 32'(ack), 32'h0);
      send_byte(8'h01, ack);
      check(!ack, "R2 ignored byte after foreign address", 32'(ack), 32'h0);
      send_byte(8'h5A, ack);
      check(!ack, "R2 ignored byte after foreign address", 32'(ack), 32'h0);
      bus_stop();
      quiet = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         rf[i]  = 16'hA5C3 ^ 16'(i * 16'h1357);
         mdl[i] = 16'hA5C3 ^ 16'(i * 16'h1357);
      end
      repeat (5) @(negedge clk);
      check(sda_oe == 1'b0, "R1 reset: SDA released", 32'(sda_oe), 32'h0);
      check(reg_we == 1'b0, "R4 reset: no write", 32'(reg_we), 32'h0);
      check(reg_addr == '0, "R3 reset pointer", 32'(reg_addr), 32'h0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      wr_txn(7'h2C, 8'd2, '{8'h12, 8'h34, 8'h56, 8'h78});
      wr_txn(7'h2F, 8'd0, '{8'hAB, 8'hCD, 8'hEF});
      foreign_txn(7'h2B);
      foreign_txn(7'h3C);
      rd_txn(7'h2D, 1'b1, 8'd2, 2);
      wr_txn(7'h2E, 8'd6, '{8'h61, 8'h62, 8'h71, 8'h72, 8'h81, 8'h82});
      rd_txn(7'h2C, 1'b1, 8'd6, 4);
      wr_txn(7'h2D, 8'd200, '{8'h99, 8'h88});
      rd_txn(7'h2E, 1'b1, 8'hF0, 2);
      wr_txn(7'h2C, 8'd1, '{8'h3C, 8'h4D});
      rd_txn(7'h2F, 1'b0, 8'd0, 1);
      rd_txn(7'h2C, 1'b1, 8'd0, 3);

      check(exp_q.size() == 0, "R4 no outstanding writes", 32'(exp_q.size()), 32'h0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule